// File: doc/BRIEF.md
# Mode-Dependent Port Data Register

This block is the data register of an eight-pin general-purpose port. It sits between a simple CPU register bus and the pins. An external port control block supplies a 2-bit mode for each pin. That mode decides four things: what a bus read returns, whether a stored write value reaches the pin, whether the output driver is on, and whether the pin's pull-up is enabled.

Only one bit of the register, the top one by default, has a storage latch that the bus can write and that can drive its pin. The other bits are input-only. For those bits the output mode is reserved, and a read in that mode or in the alternate-function mode returns low. Pin levels pass through a two-flop synchronizer before they reach the read multiplexer. Read data is registered.

There are two resets. Power-on reset clears the stored bit and all registered outputs. Manual reset clears only the read-data register, and the stored bit survives it. Sleep and standby never touch the stored bit, because it changes only on a bus write or on power-on reset.

Top module: `gpio_moded_port`

## Requirements
- R1: While `por_rst` is high at a clock edge, the stored bit, `rdata`, `pin_out`, `pin_oe` and `pullup_en` are all 0 after that edge.
- R2: A write (`wr_en` high at an edge) stores `wdata[7]` into the stored bit in every mode of pin 7, including the input modes where the pin is not driven.
- R3: Writes to bits 6..0 have no effect: `pin_out[6:0]` and `pin_oe[6:0]` stay 0, and reads of those bits never show the written value.
- R4: For bit 7, a read with mode 00 (alternate) or 01 (output) returns the stored bit.
- R5: For any bit, a read with mode 10 (input, pull-up on) or 11 (input, pull-up off) returns the pin level through a two-stage synchronizer. A pin change made just before edge k is visible to a read whose strobe is sampled at edge k+2 and later, and not at edges k or k+1.
- R6: For bits 6..0, a read with mode 00 or 01 (01 is reserved for these bits) returns 0 whatever the pin level.
- R7: `pin_out[7]` always equals the stored bit. `pin_oe[7]` is high one edge after pin 7's mode is 01, and low one edge after any other mode.
- R8: `pullup_en[i]` is high one edge after pin i's mode is 10, and low otherwise.
- R9: A `man_rst` pulse clears `rdata` to 0 and leaves the stored bit unchanged, both in the latch and at `pin_out[7]`.
- R10: `rdata` takes the read value one edge after `rd_en` is sampled high, and holds its value while `rd_en` is low and no reset is active.
- R11: Pin i's mode is `mode_vec[2i+1:2i]`, with encoding 00 alternate, 01 output, 10 input with pull-up, 11 input without pull-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Synchronous active-high power-on reset |
| man_rst | input | 1 | Synchronous active-high manual reset; clears read data only |
| wr_en | input | 1 | Bus write strobe |
| wdata | input | 8 | Bus write data; only bit 7 is kept |
| rd_en | input | 1 | Bus read strobe |
| rdata | output | 8 | Registered read data |
| mode_vec | input | 16 | Per-pin 2-bit mode codes from port control |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| pullup_en | output | 8 | Pin pull-up enables |

## Verification
The bench walks a table that mixes every mode of pin 7 with every mode of the lower pins. A design that reads the stored bit in an input mode, or lets a reserved-mode low pin show its level, returns the wrong byte there. Directed tests time the synchronizer latency edge by edge, so a design with one stage too few or too many shows the new level one read early or late. A manual reset pulse must clear the read register but keep the stored bit driving its pin; a design that ties manual reset to the latch reset loses the pin value. A write made while pin 7 is an input must still be stored and show up after the pin returns to alternate mode.

// File: rtl/gpio_moded_pkg.sv
package gpio_moded_pkg;
  typedef enum logic [1:0] {
    PM_ALT      = 2'b00,
    PM_OUT      = 2'b01,
    PM_IN_PU    = 2'b10,
    PM_IN_FLOAT = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bit_slice.sv
module gpio_bit_slice
  import gpio_moded_pkg::*;
#(
  parameter bit WRITABLE = 1'b0
) (
  input  logic       clk,
  input  logic       por_rst,
  input  logic       wr_en,
  input  logic       wr_bit,
  input  logic [1:0] mode,
  input  logic       pin_sync,
  output logic       rd_bit,
  output logic       drv_out,
  output logic       drv_oe,
  output logic       pu_en
);
  logic is_input;
  assign is_input = mode[1];

  // Pull-up enable is registered for every bit.
  always_ff @(posedge clk) begin
    if (por_rst) pu_en <= 1'b0;
    else         pu_en <= (pin_mode_e'(mode) == PM_IN_PU);
  end

  if (WRITABLE) begin : g_rw
    logic store_q;

    // Stored bit: changes only on a bus write or on power-on reset.
    always_ff @(posedge clk) begin
      if (por_rst)    store_q <= 1'b0;
      else if (wr_en) store_q <= wr_bit;
    end

    always_ff @(posedge clk) begin
      if (por_rst) drv_oe <= 1'b0;
      else         drv_oe <= (pin_mode_e'(mode) == PM_OUT);
    end

    assign drv_out = store_q;
    assign rd_bit  = is_input ? pin_sync : store_q;
  end else begin : g_ro
    logic unused_wr;
    assign unused_wr = wr_en ^ wr_bit;
    assign drv_out   = 1'b0;
    assign drv_oe    = 1'b0;
    // Alternate and reserved output modes read as low.
    assign rd_bit    = is_input ? pin_sync : 1'b0;
  end
endmodule

// File: rtl/gpio_moded_port.sv
module gpio_moded_port #(
  parameter int WIDTH       = 8,
  parameter int RW_BIT      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 por_rst,
  input  logic                 man_rst,
  input  logic                 wr_en,
  input  logic [WIDTH-1:0]     wdata,
  input  logic                 rd_en,
  output logic [WIDTH-1:0]     rdata,
  input  logic [2*WIDTH-1:0]   mode_vec,
  input  logic [WIDTH-1:0]     pin_in,
  output logic [WIDTH-1:0]     pin_out,
  output logic [WIDTH-1:0]     pin_oe,
  output logic [WIDTH-1:0]     pullup_en
);
  localparam int MODE_W = 2;

  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] rd_mux;

  gpio_sync #(
    .WIDTH (WIDTH),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (por_rst),
    .din (pin_in),
    .dout(pin_sync)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    gpio_bit_slice #(
      .WRITABLE(i == RW_BIT)
    ) u_slice (
      .clk     (clk),
      .por_rst (por_rst),
      .wr_en   (wr_en),
      .wr_bit  (wdata[i]),
      .mode    (mode_vec[MODE_W*i +: MODE_W]),
      .pin_sync(pin_sync[i]),
      .rd_bit  (rd_mux[i]),
      .drv_out (pin_out[i]),
      .drv_oe  (pin_oe[i]),
      .pu_en   (pullup_en[i])
    );
  end

  // Read register: manual reset clears it; the stored bit is untouched.
  always_ff @(posedge clk) begin
    if (por_rst || man_rst) rdata <= '0;
    else if (rd_en)         rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_moded_port_chk.sv
module gpio_moded_port_chk #(
  parameter int WIDTH  = 8,
  parameter int RW_BIT = 7
) (
  input logic               clk,
  input logic               por_rst,
  input logic               man_rst,
  input logic               wr_en,
  input logic [WIDTH-1:0]   wdata,
  input logic               rd_en,
  input logic [WIDTH-1:0]   rdata,
  input logic [2*WIDTH-1:0] mode_vec,
  input logic [WIDTH-1:0]   pin_out,
  input logic [WIDTH-1:0]   pin_oe,
  input logic [WIDTH-1:0]   pullup_en
);
  function automatic logic [WIDTH-1:0] pu_mask(input logic [2*WIDTH-1:0] m);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) r[i] = (m[2*i +: 2] == 2'b10);
    return r;
  endfunction

  assert_por_clear_R1: assert property (@(posedge clk)
    por_rst |=> (pin_out[RW_BIT] == 1'b0 && rdata == '0 && pin_oe == '0));

  assert_wr_store_R2: assert property (@(posedge clk) disable iff (por_rst)
    wr_en |=> pin_out[RW_BIT] == $past(wdata[RW_BIT]));

  assert_keep_R9: assert property (@(posedge clk) disable iff (por_rst)
    !wr_en |=> $stable(pin_out[RW_BIT]));

  assert_oe_mode_R7: assert property (@(posedge clk) disable iff (por_rst)
    1'b1 |=> pin_oe[RW_BIT] == ($past(mode_vec[2*RW_BIT +: 2]) == 2'b01));

  assert_pullup_R8: assert property (@(posedge clk) disable iff (por_rst)
    1'b1 |=> pullup_en == pu_mask($past(mode_vec)));

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (por_rst)
    (!rd_en && !man_rst) |=> $stable(rdata));

  for (genvar i = 0; i < WIDTH; i++) begin : g_low
    if (i != RW_BIT) begin : g_ro
      assert_rd_low_R6: assert property (@(posedge clk) disable iff (por_rst)
        (rd_en && !mode_vec[2*i+1]) |=> rdata[i] == 1'b0);
    end
  end
endmodule

bind gpio_moded_port gpio_moded_port_chk #(
  .WIDTH (WIDTH),
  .RW_BIT(RW_BIT)
) u_chk (
  .clk      (clk),
  .por_rst  (por_rst),
  .man_rst  (man_rst),
  .wr_en    (wr_en),
  .wdata    (wdata),
  .rd_en    (rd_en),
  .rdata    (rdata),
  .mode_vec (mode_vec),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe),
  .pullup_en(pullup_en)
);

// File: tb/gpio_moded_port_tb.sv
`timescale 1ns/1ps
module gpio_moded_port_tb;
  logic        clk = 1'b0;
  logic        por_rst, man_rst, wr_en, rd_en;
  logic [7:0]  wdata, rdata, pin_in, pin_out, pin_oe, pullup_en;
  logic [15:0] mode_vec;
  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  gpio_moded_port u_dut (
    .clk(clk), .por_rst(por_rst), .man_rst(man_rst), .wr_en(wr_en),
    .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .mode_vec(mode_vec),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pullup_en(pullup_en)
  );

  // {mode7, low-bit mode, pins, write data, expected read}
  localparam int NV = 9;
  localparam logic [27:0] VEC [NV] = '{
    {2'b01, 2'b00, 8'hFF, 8'h80, 8'h80},
    {2'b00, 2'b01, 8'hFF, 8'h7F, 8'h00},
    {2'b10, 2'b10, 8'hA5, 8'hFF, 8'hA5},
    {2'b11, 2'b11, 8'h5A, 8'h00, 8'h5A},
    {2'b01, 2'b10, 8'h3C, 8'h80, 8'hBC},
    {2'b10, 2'b00, 8'h00, 8'h80, 8'h00},
    {2'b00, 2'b11, 8'hC3, 8'h00, 8'h43},
    {2'b11, 2'b01, 8'h80, 8'h80, 8'h80},
    {2'b01, 2'b11, 8'h7E, 8'h00, 8'h7E}
  };

  function automatic logic [15:0] modes(input logic [1:0] m7, input logic [1:0] ml);
    logic [15:0] r;
    for (int i = 0; i < 7; i++) r[2*i +: 2] = ml;
    r[15:14] = m7;
    return r;
  endfunction

  function automatic logic [7:0] pu_exp(input logic [1:0] m7, input logic [1:0] ml);
    return {m7 == 2'b10, {7{ml == 2'b10}}};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_en = 1'b1; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    por_rst = 1'b1; man_rst = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wdata = '0; pin_in = 8'hFF; mode_vec = modes(2'b10, 2'b10);
    repeat (3) @(negedge clk);
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pullup_en", pullup_en, 8'h00);
    por_rst = 1'b0;
    @(negedge clk);
    chk("R8 pullup after reset", pullup_en, 8'hFF);

    // Table walk: R2 R4 R5 R6 R7 R8 R11
    for (int v = 0; v < NV; v++) begin
      logic [1:0] m7, ml;
      logic [7:0] pv, wd, ex;
      {m7, ml, pv, wd, ex} = VEC[v];
      mode_vec = modes(m7, ml);
      pin_in = pv;
      do_write(wd);
      repeat (3) @(negedge clk);
      do_read();
      chk("R4 R5 R6 R11 table read", rdata, ex);
      chk("R7 table pin_oe", pin_oe, {m7 == 2'b01, 7'b0});
      chk("R2 R7 table pin_out", pin_out, {wd[7], 7'b0});
      chk("R8 table pullup", pullup_en, pu_exp(m7, ml));
    end

    // R5: synchronizer latency
    mode_vec = modes(2'b10, 2'b10);
    pin_in = 8'h00;
    repeat (4) @(negedge clk);
    pin_in = 8'hFF;
    do_read();
    chk("R5 read at edge k", rdata, 8'h00);
    do_read();
    chk("R5 read at edge k+1", rdata, 8'h00);
    do_read();
    chk("R5 read at edge k+2", rdata, 8'hFF);

    // R10: hold without a strobe
    pin_in = 8'h00;
    repeat (5) @(negedge clk);
    chk("R10 rdata holds", rdata, 8'hFF);

    // R9: manual reset keeps the stored bit
    mode_vec = modes(2'b01, 2'b00);
    do_write(8'h80);
    do_read();
    man_rst = 1'b1;
    @(negedge clk);
    man_rst = 1'b0;
    chk("R9 rdata cleared", rdata, 8'h00);
    chk("R9 pin_out kept", pin_out, 8'h80);
    do_read();
    chk("R9 stored bit read", rdata, 8'h80);

    // R7: output enable follows the mode one edge later
    chk("R7 oe in output mode", pin_oe, 8'h80);
    mode_vec = modes(2'b10, 2'b00);
    @(negedge clk);
    chk("R7 oe off in input mode", pin_oe, 8'h00);
    chk("R7 pin_out retained", pin_out, 8'h80);

    // R3 R6: low bits in reserved output mode ignore writes
    mode_vec = modes(2'b01, 2'b01);
    pin_in = 8'hFF;
    do_write(8'hFF);
    repeat (3) @(negedge clk);
    do_read();
    chk("R3 R6 reserved read", rdata, 8'h80);
    chk("R3 low pin_out", pin_out, 8'h80);
    chk("R3 low pin_oe", pin_oe, 8'h80);

    // R1: power-on reset clears the stored bit
    por_rst = 1'b1;
    @(negedge clk);
    por_rst = 1'b0;
    chk("R1 por pin_out", pin_out, 8'h00);
    chk("R1 por pin_oe", pin_oe, 8'h00);
    chk("R1 por rdata", rdata, 8'h00);

    // R2: write while pin 7 is an input is still stored
    mode_vec = modes(2'b11, 2'b00);
    do_write(8'h80);
    chk("R2 not driven in input mode", pin_oe, 8'h00);
    mode_vec = modes(2'b00, 2'b00);
    repeat (2) @(negedge clk);
    do_read();
    chk("R2 R4 stored in input mode", rdata, 8'h80);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule